// File: doc/BRIEF.md
# Broadcast Channel Register Bank

This block holds the control words of a four-channel tone generator. Every channel answers to the same two word addresses, one for the frequency tuning word and one for the phase offset word. A channel-select register, written at its own address, carries one enable bit per channel. A write to a word address reaches the pending buffer of every channel whose enable bit is set. Software can therefore program one channel, a chosen subset, or all channels with a single write sequence.

Pending words stay invisible at the outputs until an update strobe arrives. The strobe pin is asynchronous. It is synchronized to the core clock and reduced to a single-cycle pulse on its rising edge. That pulse moves every channel's pending words into its active registers on the same clock edge. The enable bits and the I/O mode field are not buffered. They take effect on the clock edge that accepts the channel-select write.

The write port is a valid/ready port with no back-pressure: `wr_ready` is always high, and a beat is accepted on every clock edge where `wr_valid` is high. The read port is combinational from `rd_addr`.

Top module: `rb_bcast_bank`

## Requirements
- R1: While `rst` is high and after it falls, all enable bits read 1, the I/O mode field reads 00 (single-bit serial), and every pending and active word is zero.
- R2: An accepted write to address 0x00 loads the enable bits from data bits [3:0] and the I/O mode from bits [5:4]. Both are visible on `ch_en_o` and `io_mode_o` after that clock edge, with no update strobe. Otherwise they hold.
- R3: An accepted write to address 0x04 shifts the data byte into the low end of the 32-bit pending frequency word of every enabled channel (new = {old[23:0], byte}). Four writes therefore load a word most significant byte first.
- R4: An accepted write to address 0x05 shifts the byte into the 14-bit pending phase word of every enabled channel (new = {old[5:0], byte}). Of a two-byte sequence, the upper two bits of the first byte are dropped.
- R5: A write to 0x04 or 0x05 while no enable bit is set changes no channel's buffer.
- R6: Active outputs change only on the internal update pulse, and all channels change on the same edge. The new words appear on the third rising clock edge after `upd_in` rises.
- R7: The update acts on the rising edge of `upd_in` only. Holding it high transfers once. Writes made while it stays high reach the outputs only at its next rising edge.
- R8: A read of 0x04 or 0x05 returns, zero-extended, the pending word of the lowest-numbered enabled channel. With no channel enabled it returns zero. A read of 0x00 returns {I/O mode, enable bits} in bits [5:0]. Any other address reads zero.
- R9: A write to any address other than 0x00, 0x04 and 0x05 changes no register.
- R10: `wr_ready` is high in every cycle, so every beat with `wr_valid` high is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high master reset |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Write beat accepted (always high) |
| wr_addr | input | 8 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 8 | Read register address |
| rd_data | output | 32 | Combinational read data, zero-extended |
| upd_in | input | 1 | Asynchronous update strobe, rising-edge active |
| freq_o | output | 128 | Active frequency words, channel 0 in the low 32 bits |
| phase_o | output | 56 | Active phase words, channel 0 in the low 14 bits |
| ch_en_o | output | 4 | Current channel enable bits |
| io_mode_o | output | 2 | Current serial I/O mode field |

## Verification
The assertions check several properties on every cycle. The active words stay frozen outside the update pulse, and that pulse never lasts two cycles. Enable bits follow a channel-select write on the next edge and hold at all other times. Word reads return zero when no channel is enabled or the address is unknown. The bench's scenarios cover the rest: the byte order of the shift-in, the dropped phase bits, the broadcast to exact channel subsets, the lowest-channel read priority, the three-edge update latency, and the single transfer while the strobe is held high. Each of these depends on data history that only a reference model, fed the same writes, can predict.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [1:0] {
    IOM_1BIT = 2'b00,
    IOM_2BIT = 2'b01,
    IOM_4BIT = 2'b10,
    IOM_RSVD = 2'b11
  } io_mode_e;

  typedef struct packed {
    logic sel_wr;
    logic ftw_wr;
    logic pow_wr;
  } wr_dec_t;
endpackage

// File: rtl/rb_update_sync.sv
module rb_update_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic pulse
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  // single-cycle pulse on the synchronized rising edge
  assign pulse = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/rb_channel.sv
module rb_channel #(
  parameter int FTW_W   = 32,
  parameter int PHASE_W = 14,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               ftw_wr,
  input  logic               pow_wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               upd,
  output logic [FTW_W-1:0]   pend_ftw,
  output logic [PHASE_W-1:0] pend_pow,
  output logic [FTW_W-1:0]   act_ftw,
  output logic [PHASE_W-1:0] act_pow
);
  logic [FTW_W-1:0]   ftw_next;
  logic [PHASE_W-1:0] pow_next;

  // shift-in of a byte at the low end; wide words fill MSB first
  generate
    if (FTW_W > DATA_W) begin : g_ftw_shift
      assign ftw_next = {pend_ftw[FTW_W-DATA_W-1:0], wdata};
    end else begin : g_ftw_direct
      assign ftw_next = wdata[FTW_W-1:0];
    end
    if (PHASE_W > DATA_W) begin : g_pow_shift
      assign pow_next = {pend_pow[PHASE_W-DATA_W-1:0], wdata};
    end else begin : g_pow_direct
      assign pow_next = wdata[PHASE_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_ftw <= '0;
      pend_pow <= '0;
    end else if (sel) begin
      if (ftw_wr) pend_ftw <= ftw_next;
      if (pow_wr) pend_pow <= pow_next;
    end
  end

  // active copy takes the pending value held before this edge
  always_ff @(posedge clk) begin
    if (rst) begin
      act_ftw <= '0;
      act_pow <= '0;
    end else if (upd) begin
      act_ftw <= pend_ftw;
      act_pow <= pend_pow;
    end
  end
endmodule

// File: rtl/rb_read_mux.sv
module rb_read_mux #(
  parameter int NUM_CH = 4,
  parameter int W      = 32
) (
  input  logic [NUM_CH-1:0]   en,
  input  logic [NUM_CH*W-1:0] words,
  output logic [W-1:0]        sel_word
);
  // lowest enabled channel wins; walk downward so it is assigned last
  always_comb begin
    sel_word = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (en[i]) sel_word = words[i*W +: W];
    end
  end
endmodule

// File: rtl/rb_bcast_bank.sv
module rb_bcast_bank
  import rb_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int FTW_W       = 32,
  parameter int PHASE_W     = 14,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int RD_W        = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] FTW_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] POW_ADDR = 8'h05
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [RD_W-1:0]           rd_data,
  input  logic                      upd_in,
  output logic [NUM_CH*FTW_W-1:0]   freq_o,
  output logic [NUM_CH*PHASE_W-1:0] phase_o,
  output logic [NUM_CH-1:0]         ch_en_o,
  output logic [1:0]                io_mode_o
);
  localparam int IOM_LSB = NUM_CH;
  localparam int CSR_W   = NUM_CH + 2;

  logic [NUM_CH-1:0]         en_q;
  io_mode_e                  iom_q;
  wr_dec_t                   dec;
  logic                      upd_pulse;
  logic [NUM_CH*FTW_W-1:0]   pend_ftw_all;
  logic [NUM_CH*PHASE_W-1:0] pend_pow_all;
  logic [FTW_W-1:0]          rd_ftw;
  logic [PHASE_W-1:0]        rd_pow;

  assign wr_ready = 1'b1;

  always_comb begin
    dec        = '0;
    dec.sel_wr = wr_valid && (wr_addr == CSR_ADDR);
    dec.ftw_wr = wr_valid && (wr_addr == FTW_ADDR);
    dec.pow_wr = wr_valid && (wr_addr == POW_ADDR);
  end

  // channel-select register: no staging, effective on the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '1;
      iom_q <= IOM_1BIT;
    end else if (dec.sel_wr) begin
      en_q  <= wr_data[NUM_CH-1:0];
      iom_q <= io_mode_e'(wr_data[IOM_LSB +: 2]);
    end
  end

  assign ch_en_o   = en_q;
  assign io_mode_o = iom_q;

  rb_update_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (upd_in),
    .pulse    (upd_pulse)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      rb_channel #(
        .FTW_W   (FTW_W),
        .PHASE_W (PHASE_W),
        .DATA_W  (DATA_W)
      ) u_ch (
        .clk      (clk),
        .rst      (rst),
        .sel      (en_q[c]),
        .ftw_wr   (dec.ftw_wr),
        .pow_wr   (dec.pow_wr),
        .wdata    (wr_data),
        .upd      (upd_pulse),
        .pend_ftw (pend_ftw_all[c*FTW_W +: FTW_W]),
        .pend_pow (pend_pow_all[c*PHASE_W +: PHASE_W]),
        .act_ftw  (freq_o[c*FTW_W +: FTW_W]),
        .act_pow  (phase_o[c*PHASE_W +: PHASE_W])
      );
    end
  endgenerate

  rb_read_mux #(.NUM_CH(NUM_CH), .W(FTW_W)) u_rd_ftw (
    .en       (en_q),
    .words    (pend_ftw_all),
    .sel_word (rd_ftw)
  );

  rb_read_mux #(.NUM_CH(NUM_CH), .W(PHASE_W)) u_rd_pow (
    .en       (en_q),
    .words    (pend_pow_all),
    .sel_word (rd_pow)
  );

  always_comb begin
    if (rd_addr == CSR_ADDR)      rd_data = RD_W'({iom_q, en_q});
    else if (rd_addr == FTW_ADDR) rd_data = RD_W'(rd_ftw);
    else if (rd_addr == POW_ADDR) rd_data = RD_W'(rd_pow);
    else                          rd_data = '0;
  end

  logic [CSR_W-1:0] unused_csr_w;
  assign unused_csr_w = '0;
endmodule

// File: rtl/rb_bcast_bank_chk.sv
module rb_bcast_bank_chk #(
  parameter int NUM_CH  = 4,
  parameter int FTW_W   = 32,
  parameter int PHASE_W = 14,
  parameter int ADDR_W  = 8,
  parameter int RD_W    = 32,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] FTW_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] POW_ADDR = 8'h05
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wr_valid,
  input logic                      wr_ready,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic [NUM_CH-1:0]         wr_en_bits,
  input logic [ADDR_W-1:0]         rd_addr,
  input logic [RD_W-1:0]           rd_data,
  input logic                      upd_pulse,
  input logic [NUM_CH*FTW_W-1:0]   freq_o,
  input logic [NUM_CH*PHASE_W-1:0] phase_o,
  input logic [NUM_CH-1:0]         ch_en_o
);
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd_pulse |=> ($stable(freq_o) && $stable(phase_o))); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |=> !upd_pulse); // R7

  AST_CSR_TAKE: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && wr_addr == CSR_ADDR) |=> (ch_en_o == $past(wr_en_bits))); // R2

  AST_CSR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && wr_addr == CSR_ADDR) |=> $stable(ch_en_o)); // R2

  AST_RD_NONE_EN: assert property (@(posedge clk) disable iff (rst)
    (ch_en_o == '0 && (rd_addr == FTW_ADDR || rd_addr == POW_ADDR)) |-> (rd_data == '0)); // R8

  AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
    (rd_addr != CSR_ADDR && rd_addr != FTW_ADDR && rd_addr != POW_ADDR) |-> (rd_data == '0)); // R8
endmodule

bind rb_bcast_bank rb_bcast_bank_chk #(
  .NUM_CH   (NUM_CH),
  .FTW_W    (FTW_W),
  .PHASE_W  (PHASE_W),
  .ADDR_W   (ADDR_W),
  .RD_W     (RD_W),
  .CSR_ADDR (CSR_ADDR),
  .FTW_ADDR (FTW_ADDR),
  .POW_ADDR (POW_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_en_bits (wr_data[NUM_CH-1:0]),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .upd_pulse  (upd_pulse),
  .freq_o     (freq_o),
  .phase_o    (phase_o),
  .ch_en_o    (ch_en_o)
);

// File: tb/rb_bcast_bank_tb_top.sv
module rb_bcast_bank_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [7:0]   wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic [7:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic         upd_in = 1'b0;
  logic [127:0] freq_o;
  logic [55:0]  phase_o;
  logic [3:0]   ch_en_o;
  logic [1:0]   io_mode_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [3:0]  m_en;
  logic [1:0]  m_iom;
  logic [31:0] m_pf [4];
  logic [13:0] m_pp [4];
  logic [31:0] m_af [4];
  logic [13:0] m_ap [4];

  always #2 clk = ~clk;

  rb_bcast_bank dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .upd_in(upd_in), .freq_o(freq_o), .phase_o(phase_o), .ch_en_o(ch_en_o),
    .io_mode_o(io_mode_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] r = '0;
    if (a == 8'h00) r = {26'b0, m_iom, m_en};
    else if (a == 8'h04 || a == 8'h05) begin
      for (int i = 3; i >= 0; i--)
        if (m_en[i]) r = (a == 8'h04) ? m_pf[i] : {18'b0, m_pp[i]};
    end
    return r;
  endfunction

  task automatic model_reset();
    m_en = 4'hF; m_iom = 2'b00;
    for (int i = 0; i < 4; i++) begin
      m_pf[i] = '0; m_pp[i] = '0; m_af[i] = '0; m_ap[i] = '0;
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h00) begin
      m_en = d[3:0]; m_iom = d[5:4];
    end else if (a == 8'h04 || a == 8'h05) begin
      for (int i = 0; i < 4; i++) if (m_en[i]) begin
        if (a == 8'h04) m_pf[i] = {m_pf[i][23:0], d};
        else            m_pp[i] = {m_pp[i][5:0], d};
      end
    end
  endtask

  task automatic model_copy();
    for (int i = 0; i < 4; i++) begin
      m_af[i] = m_pf[i]; m_ap[i] = m_pp[i];
    end
  endtask

  // compare active outputs and enables against the model
  task automatic check_active(input string req);
    for (int i = 0; i < 4; i++) begin
      chk(req, freq_o[i*32 +: 32], m_af[i]);
      chk(req, {18'b0, phase_o[i*14 +: 14]}, {18'b0, m_ap[i]});
    end
  endtask

  task automatic check_reads(input string req);
    logic [7:0] addrs [4] = '{8'h00, 8'h04, 8'h05, 8'h09};
    for (int k = 0; k < 4; k++) begin
      rd_addr = addrs[k];
      #0.5;
      chk(req, rd_data, exp_read(addrs[k]));
    end
    chk(req, {28'b0, ch_en_o}, {28'b0, m_en});
    chk(req, {30'b0, io_mode_o}, {30'b0, m_iom});
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    chk("R10", {31'b0, wr_ready}, 32'd1);
    @(negedge clk);
    wr_valid = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_update();
    @(negedge clk);
    upd_in = 1'b1;
    repeat (2) @(negedge clk);
    check_active("R6 before third edge");
    @(negedge clk);
    model_copy();
    check_active("R6 after third edge");
    upd_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(negedge clk);
    check_active("R1 in reset");
    check_reads("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_active("R1 after reset");
    check_reads("R1 after reset");

    // R3 broadcast of a full word, MSB first, to all channels
    do_write(8'h04, 8'hDE); do_write(8'h04, 8'hAD);
    do_write(8'h04, 8'hBE); do_write(8'h04, 8'hEF);
    check_reads("R3 broadcast");
    rd_addr = 8'h04; #0.5;
    chk("R3 byte order", rd_data, 32'hDEADBEEF);
    // R4 phase: top two bits of the first byte dropped
    do_write(8'h05, 8'hFF); do_write(8'h05, 8'h12);
    rd_addr = 8'h05; #0.5;
    chk("R4 phase trim", rd_data, 32'h00003F12);
    check_active("R6 pending not visible");
    do_update();

    // R2 enables immediate; per-channel programming
    for (int c = 0; c < 4; c++) begin
      do_write(8'h00, 8'(1 << c));
      check_reads("R2 enable immediate");
      for (int b = 0; b < 4; b++) do_write(8'h04, 8'(8'h10 * c + b));
      do_write(8'h05, 8'(c)); do_write(8'h05, 8'(8'h40 + c));
      check_reads("R8 single channel read");
    end
    // R8 lowest enabled wins
    do_write(8'h00, 8'b0010_1100);
    check_reads("R8 lowest priority");
    do_update();

    // R5 writes with no channel enabled
    do_write(8'h00, 8'h00);
    check_reads("R8 none enabled");
    do_write(8'h04, 8'h77); do_write(8'h05, 8'h66);
    do_write(8'h00, 8'h0F);
    check_reads("R5 discarded write");
    // R9 unmapped write
    do_write(8'h07, 8'h3A); do_write(8'h01, 8'h0C);
    check_reads("R9 unmapped write");

    // R7 strobe held high: one transfer only
    do_write(8'h04, 8'h55);
    @(negedge clk); upd_in = 1'b1;
    repeat (3) @(negedge clk);
    model_copy();
    check_active("R7 first edge transfer");
    do_write(8'h04, 8'hAA);
    repeat (5) @(negedge clk);
    check_active("R7 no repeat while high");
    upd_in = 1'b0;
    repeat (3) @(negedge clk);
    do_update();

    // constrained random mix
    for (int it = 0; it < 300; it++) begin
      int unsigned op = $urandom_range(0, 9);
      if (op < 2)      do_write(8'h00, 8'($urandom_range(0, 63)));
      else if (op < 5) do_write(8'h04, 8'($urandom));
      else if (op < 7) do_write(8'h05, 8'($urandom));
      else if (op < 8) do_write(8'($urandom_range(6, 255)), 8'($urandom));
      else             do_update();
      check_reads("R3 R4 R8 random");
      check_active("R6 random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule